// File: doc/BRIEF.md
# Performance Monitor Register Bank

This block is the system-register front end of a performance monitor for a core that has no event counters. An access arrives on a single-cycle port: a strobe, a write flag, a two-part selector (a 4-bit register group and a 3-bit index within it), 32 bits of write data and a privilege bit. One clock edge later the bank presents the read data and an "undefined" flag. The core's exception logic uses that flag to trap the instruction.

The bank holds these registers:

- a control word whose top byte is copied from the core's identification word;
- a count-enable word and an interrupt-enable word, each reached through a set alias and a clear alias;
- an overflow status word with write-one-to-clear behaviour;
- an event type byte;
- a user-access enable bit.

The cycle counter, event counter, counter select and software increment slots exist only so that software finds them. They hold nothing.

Access rights fall into three classes. The interrupt-enable aliases are for privileged code only. The user-access enable bit is readable by everyone but writable only at privileged level. Every other register is open to user code only while the user-access enable bit is set.

Top module: `perfmon_bank`

## Requirements
- R1: On reset (synchronous, `rst_n` low) the control word becomes the top 8 bits of `id_value` with all lower bits zero. Count-enable, interrupt-enable, overflow status, event type and user-access enable all become zero.
- R2: A write to the control word changes only bits 0, 3, 4 and 5 (mask 0x39) to the written values. Every other bit keeps its previous value.
- R3: Count-enable has a set alias (group 12, index 1) and a clear alias (group 12, index 2), and both read the same value. A set write ORs in bit 31 of the data, and a clear write removes bit 31 if it is written as 1. All other data bits are ignored.
- R4: Interrupt-enable behaves like count-enable through its set alias (group 14, index 1) and its clear alias (group 14, index 2), again on bit 31 only. Any user-level access to either alias is undefined.
- R5: A write to overflow status (group 12, index 3) clears every bit written as 1. No source sets its bits, so it always reads zero.
- R6: The event type register (group 13, index 1) stores bits 7:0 of the write data and reads them back zero-extended.
- R7: The user-access enable register (group 14, index 0) stores only bit 0. At user level a read is allowed and a write is undefined and leaves the bit unchanged. At privileged level both reads and writes are allowed.
- R8: Control, both count-enable aliases, overflow status, software increment, counter select, cycle counter, event type and event counter are undefined at user level while the user-access enable bit is 0, and accessible while it is 1.
- R9: The cycle counter (group 13, index 0), event counter (group 13, index 2) and counter select (group 12, index 5) read as zero and ignore writes. Software increment (group 12, index 4) accepts writes with no effect, and a read of it is undefined.
- R10: Any selector outside these groups and indexes is undefined: group 12 above index 5, groups 13 and 14 above index 2, and every other group. An undefined access changes no state and returns zero data.
- R11: `rd_data` and `acc_undef` reflect the access presented at the previous clock edge. A write returns zero data, and a cycle without a strobe is followed by zero data with `acc_undef` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_value | input | 32 | Core identification word; its top byte seeds the control word |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_crm | input | 4 | Register group selector |
| acc_op2 | input | 3 | Register index within the group |
| acc_wdata | input | 32 | Write data |
| acc_priv | input | 1 | 1 = privileged level, 0 = user level |
| rd_data | output | 32 | Read data for the previous cycle's access |
| acc_undef | output | 1 | Previous cycle's access was undefined |

## Verification
On every cycle, the in-RTL properties check four things:
- the privilege rules (user access to interrupt-enable, gated registers while user access is off, user writes to the enable bit);
- that unmapped selectors always trap;
- that writes and idle cycles return zero;
- that the fixed control bits and idle set/clear words never move.

Only the bench scenarios can show the stored values themselves. That covers the masked control update, the bit-31 aliasing between set and clear addresses, the event-type truncation and the placeholder slots reading zero. It also covers the fact that a trapped access or an unmapped write leaves every register as it was, which the bench confirms by reading the registers back afterwards.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

   // Register group numbers; the software-visible map depends on these.
   localparam int unsigned GRP_CTL = 12;
   localparam int unsigned GRP_CNT = 13;
   localparam int unsigned GRP_USR = 14;

   typedef enum logic [3:0] {
      SEL_CTRL,
      SEL_CEN_SET,
      SEL_CEN_CLR,
      SEL_OVS,
      SEL_SWINC,
      SEL_CSEL,
      SEL_CYC,
      SEL_EVTYPE,
      SEL_EVCNT,
      SEL_UEN,
      SEL_IEN_SET,
      SEL_IEN_CLR,
      SEL_NONE
   } sel_e;

   typedef enum logic [1:0] {
      CLS_GATED,
      CLS_USER_RO,
      CLS_PRIV_ONLY,
      CLS_BAD
   } cls_e;

endpackage

// File: rtl/perfmon_decode.sv
module perfmon_decode
   import perfmon_pkg::*;
#(
   parameter int unsigned CRM_W = 4,
   parameter int unsigned OP2_W = 3
) (
   input  logic [CRM_W-1:0] crm,
   input  logic [OP2_W-1:0] op2,
   output sel_e             sel,
   output cls_e             cls
);

   localparam logic [CRM_W-1:0] G_CTL = CRM_W'(GRP_CTL);
   localparam logic [CRM_W-1:0] G_CNT = CRM_W'(GRP_CNT);
   localparam logic [CRM_W-1:0] G_USR = CRM_W'(GRP_USR);

   always_comb begin
      sel = SEL_NONE;
      if (crm == G_CTL) begin
         case (op2)
            OP2_W'(0): sel = SEL_CTRL;
            OP2_W'(1): sel = SEL_CEN_SET;
            OP2_W'(2): sel = SEL_CEN_CLR;
            OP2_W'(3): sel = SEL_OVS;
            OP2_W'(4): sel = SEL_SWINC;
            OP2_W'(5): sel = SEL_CSEL;
            default:   sel = SEL_NONE;
         endcase
      end else if (crm == G_CNT) begin
         case (op2)
            OP2_W'(0): sel = SEL_CYC;
            OP2_W'(1): sel = SEL_EVTYPE;
            OP2_W'(2): sel = SEL_EVCNT;
            default:   sel = SEL_NONE;
         endcase
      end else if (crm == G_USR) begin
         case (op2)
            OP2_W'(0): sel = SEL_UEN;
            OP2_W'(1): sel = SEL_IEN_SET;
            OP2_W'(2): sel = SEL_IEN_CLR;
            default:   sel = SEL_NONE;
         endcase
      end
   end

   always_comb begin
      case (sel)
         SEL_NONE:                 cls = CLS_BAD;
         SEL_UEN:                  cls = CLS_USER_RO;
         SEL_IEN_SET, SEL_IEN_CLR: cls = CLS_PRIV_ONLY;
         default:                  cls = CLS_GATED;
      endcase
   end

endmodule

// File: rtl/perfmon_access.sv
module perfmon_access
   import perfmon_pkg::*;
(
   input  logic valid,
   input  logic write,
   input  logic priv,
   input  logic user_en,
   input  sel_e sel,
   input  cls_e cls,
   output logic allow,
   output logic undef
);

   logic bad_slot;
   logic user_block;

   // Software increment has no readable value.
   assign bad_slot = (cls == CLS_BAD) || ((sel == SEL_SWINC) && !write);

   always_comb begin
      user_block = 1'b0;
      if (!priv) begin
         case (cls)
            CLS_GATED:     user_block = !user_en;
            CLS_USER_RO:   user_block = write;
            CLS_PRIV_ONLY: user_block = 1'b1;
            default:       user_block = 1'b1;
         endcase
      end
   end

   assign undef = valid && (bad_slot || user_block);
   assign allow = valid && !bad_slot && !user_block;

endmodule

// File: rtl/perfmon_setclr.sv
module perfmon_setclr #(
   parameter int unsigned        W    = 32,
   parameter logic [W-1:0]       MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_i,
   input  logic         clr_i,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   logic unused_wdata;
   assign unused_wdata = ^(wdata & ~MASK);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (MASK[i]) begin : g_live
         always_ff @(posedge clk) begin
            if (!rst_n)                  q[i] <= 1'b0;
            else if (set_i && wdata[i])  q[i] <= 1'b1;
            else if (clr_i && wdata[i])  q[i] <= 1'b0;
         end
      end else begin : g_tied
         assign q[i] = 1'b0;
      end
   end

   // R3 (and R4): the word moves only on a set or clear alias write.
   p_setclr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(q));

endmodule

// File: rtl/perfmon_bank.sv
module perfmon_bank
   import perfmon_pkg::*;
#(
   parameter int unsigned   DATA_W     = 32,
   parameter int unsigned   CRM_W      = 4,
   parameter int unsigned   OP2_W      = 3,
   parameter int unsigned   IMPL_W     = 8,
   parameter int unsigned   EVT_W      = 8,
   parameter logic [31:0]   CTRL_WMASK = 32'h0000_0039,
   parameter int unsigned   CYC_BIT    = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] id_value,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [CRM_W-1:0]  acc_crm,
   input  logic [OP2_W-1:0]  acc_op2,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic              acc_priv,
   output logic [DATA_W-1:0] rd_data,
   output logic              acc_undef
);

   if (IMPL_W == 0 || IMPL_W >= DATA_W) begin : g_bad_impl
      $error("perfmon_bank: IMPL_W must be between 1 and DATA_W-1");
   end
   if (EVT_W == 0 || EVT_W > DATA_W) begin : g_bad_evt
      $error("perfmon_bank: EVT_W must be between 1 and DATA_W");
   end
   if (CYC_BIT >= DATA_W) begin : g_bad_cyc
      $error("perfmon_bank: CYC_BIT outside the data word");
   end
   if (CRM_W < 4 || OP2_W < 3) begin : g_bad_sel
      $error("perfmon_bank: selector too narrow for the register map");
   end

   localparam logic [DATA_W-1:0] IMPL_MASK = {{IMPL_W{1'b1}}, {(DATA_W-IMPL_W){1'b0}}};
   localparam logic [DATA_W-1:0] WMASK     = DATA_W'(CTRL_WMASK) & ~IMPL_MASK;
   localparam logic [DATA_W-1:0] CYC_MASK  = DATA_W'(1) << CYC_BIT;

   sel_e              sel;
   cls_e              cls;
   logic              allow;
   logic              undef_c;
   logic              wr_ok;
   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] ovs_q;
   logic [EVT_W-1:0]  evt_q;
   logic              uen_q;
   logic [DATA_W-1:0] cen_q;
   logic [DATA_W-1:0] ien_q;
   logic [DATA_W-1:0] rmux;

   perfmon_decode #(.CRM_W(CRM_W), .OP2_W(OP2_W)) u_decode (
      .crm (acc_crm),
      .op2 (acc_op2),
      .sel (sel),
      .cls (cls)
   );

   perfmon_access u_access (
      .valid   (acc_valid),
      .write   (acc_write),
      .priv    (acc_priv),
      .user_en (uen_q),
      .sel     (sel),
      .cls     (cls),
      .allow   (allow),
      .undef   (undef_c)
   );

   assign wr_ok = allow && acc_write;

   // Control word: implementor byte from id_value, masked writable bits.
   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl_q <= id_value & IMPL_MASK;
      else if (wr_ok && sel == SEL_CTRL)
         ctrl_q <= (ctrl_q & ~WMASK) | (acc_wdata & WMASK);
   end

   // Overflow status: write-one-to-clear, no set source without counters.
   for (genvar i = 0; i < DATA_W; i++) begin : g_ovs
      if (CYC_MASK[i]) begin : g_live
         always_ff @(posedge clk) begin
            if (!rst_n)
               ovs_q[i] <= 1'b0;
            else if (wr_ok && sel == SEL_OVS && acc_wdata[i])
               ovs_q[i] <= 1'b0;
         end
      end else begin : g_tied
         assign ovs_q[i] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_q <= '0;
         uen_q <= 1'b0;
      end else if (wr_ok) begin
         if (sel == SEL_EVTYPE) evt_q <= acc_wdata[EVT_W-1:0];
         if (sel == SEL_UEN)    uen_q <= acc_wdata[0];
      end
   end

   perfmon_setclr #(.W(DATA_W), .MASK(CYC_MASK)) u_cen (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (wr_ok && sel == SEL_CEN_SET),
      .clr_i (wr_ok && sel == SEL_CEN_CLR),
      .wdata (acc_wdata),
      .q     (cen_q)
   );

   perfmon_setclr #(.W(DATA_W), .MASK(CYC_MASK)) u_ien (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (wr_ok && sel == SEL_IEN_SET),
      .clr_i (wr_ok && sel == SEL_IEN_CLR),
      .wdata (acc_wdata),
      .q     (ien_q)
   );

   always_comb begin
      case (sel)
         SEL_CTRL:                 rmux = ctrl_q;
         SEL_CEN_SET, SEL_CEN_CLR: rmux = cen_q;
         SEL_OVS:                  rmux = ovs_q;
         SEL_EVTYPE:               rmux = DATA_W'(evt_q);
         SEL_UEN:                  rmux = DATA_W'(uen_q);
         SEL_IEN_SET, SEL_IEN_CLR: rmux = ien_q;
         default:                  rmux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data   <= '0;
         acc_undef <= 1'b0;
      end else begin
         acc_undef <= undef_c;
         rd_data   <= (allow && !acc_write) ? rmux : '0;
      end
   end

   // R2: bits outside the writable mask never change once out of reset.
   p_ctrl_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(ctrl_q & ~WMASK));

   // R4: user access to either interrupt-enable alias always traps.
   p_user_ien_undef_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_priv && acc_crm == CRM_W'(GRP_USR)
       && (acc_op2 == OP2_W'(1) || acc_op2 == OP2_W'(2))) |=> acc_undef);

   // R7: a user write to the enable bit traps and leaves it unchanged.
   p_uen_user_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && !acc_priv && sel == SEL_UEN)
      |=> (acc_undef && $stable(uen_q)));

   // R8: gated registers trap at user level while access is off.
   p_gated_user_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_priv && cls == CLS_GATED && !uen_q) |=> acc_undef);

   // R10: unmapped selectors trap.
   p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && sel == SEL_NONE) |=> (acc_undef && rd_data == '0));

   // R11: writes and idle cycles return zero data.
   p_write_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write) |=> rd_data == '0);
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (rd_data == '0 && !acc_undef));

endmodule

// File: tb/perfmon_bank_bench.sv
module perfmon_bank_bench;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        wr;
      logic        pv;
      logic [3:0]  crm;
      logic [2:0]  op2;
      logic [31:0] wd;
      logic        xu;
      logic [31:0] xd;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 58;
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b1,4'd12,3'd0,32'h0,        1'b0,32'h41000000,4'd1},  // R1
      '{1'b0,1'b1,4'd12,3'd1,32'h0,        1'b0,32'h0,       4'd1},  // R1
      '{1'b0,1'b1,4'd13,3'd1,32'h0,        1'b0,32'h0,       4'd1},  // R1
      '{1'b0,1'b1,4'd14,3'd0,32'h0,        1'b0,32'h0,       4'd1},  // R1
      '{1'b0,1'b1,4'd14,3'd1,32'h0,        1'b0,32'h0,       4'd1},  // R1
      '{1'b1,1'b1,4'd12,3'd0,32'hFFFFFFFF, 1'b0,32'h0,       4'd2},  // R2
      '{1'b0,1'b1,4'd12,3'd0,32'h0,        1'b0,32'h41000039,4'd2},  // R2
      '{1'b1,1'b1,4'd12,3'd0,32'h00FF00C6, 1'b0,32'h0,       4'd2},  // R2
      '{1'b0,1'b1,4'd12,3'd0,32'h0,        1'b0,32'h41000000,4'd2},  // R2
      '{1'b1,1'b1,4'd12,3'd1,32'hFFFFFFFF, 1'b0,32'h0,       4'd3},  // R3
      '{1'b0,1'b1,4'd12,3'd1,32'h0,        1'b0,32'h80000000,4'd3},  // R3
      '{1'b0,1'b1,4'd12,3'd2,32'h0,        1'b0,32'h80000000,4'd3},  // R3
      '{1'b1,1'b1,4'd12,3'd2,32'h7FFFFFFF, 1'b0,32'h0,       4'd3},  // R3
      '{1'b0,1'b1,4'd12,3'd1,32'h0,        1'b0,32'h80000000,4'd3},  // R3
      '{1'b1,1'b1,4'd12,3'd2,32'h80000000, 1'b0,32'h0,       4'd3},  // R3
      '{1'b0,1'b1,4'd12,3'd2,32'h0,        1'b0,32'h0,       4'd3},  // R3
      '{1'b1,1'b1,4'd12,3'd3,32'hFFFFFFFF, 1'b0,32'h0,       4'd5},  // R5
      '{1'b0,1'b1,4'd12,3'd3,32'h0,        1'b0,32'h0,       4'd5},  // R5
      '{1'b1,1'b1,4'd13,3'd1,32'h12345678, 1'b0,32'h0,       4'd6},  // R6
      '{1'b0,1'b1,4'd13,3'd1,32'h0,        1'b0,32'h78,      4'd6},  // R6
      '{1'b1,1'b1,4'd13,3'd0,32'hFFFFFFFF, 1'b0,32'h0,       4'd9},  // R9
      '{1'b0,1'b1,4'd13,3'd0,32'h0,        1'b0,32'h0,       4'd9},  // R9
      '{1'b1,1'b1,4'd13,3'd2,32'h0000FFFF, 1'b0,32'h0,       4'd9},  // R9
      '{1'b0,1'b1,4'd13,3'd2,32'h0,        1'b0,32'h0,       4'd9},  // R9
      '{1'b1,1'b1,4'd12,3'd5,32'h0000001F, 1'b0,32'h0,       4'd9},  // R9
      '{1'b0,1'b1,4'd12,3'd5,32'h0,        1'b0,32'h0,       4'd9},  // R9
      '{1'b1,1'b1,4'd12,3'd4,32'h1,        1'b0,32'h0,       4'd9},  // R9
      '{1'b0,1'b1,4'd12,3'd4,32'h0,        1'b1,32'h0,       4'd9},  // R9
      '{1'b1,1'b1,4'd14,3'd1,32'hFFFFFFFF, 1'b0,32'h0,       4'd4},  // R4
      '{1'b0,1'b1,4'd14,3'd2,32'h0,        1'b0,32'h80000000,4'd4},  // R4
      '{1'b1,1'b1,4'd14,3'd2,32'h80000000, 1'b0,32'h0,       4'd4},  // R4
      '{1'b0,1'b1,4'd14,3'd1,32'h0,        1'b0,32'h0,       4'd4},  // R4
      '{1'b1,1'b1,4'd14,3'd1,32'h80000000, 1'b0,32'h0,       4'd4},  // R4
      '{1'b0,1'b0,4'd14,3'd0,32'h0,        1'b0,32'h0,       4'd7},  // R7
      '{1'b1,1'b0,4'd14,3'd0,32'h1,        1'b1,32'h0,       4'd7},  // R7
      '{1'b0,1'b0,4'd14,3'd0,32'h0,        1'b0,32'h0,       4'd7},  // R7
      '{1'b0,1'b0,4'd12,3'd0,32'h0,        1'b1,32'h0,       4'd8},  // R8
      '{1'b1,1'b0,4'd13,3'd1,32'hAB,       1'b1,32'h0,       4'd8},  // R8
      '{1'b0,1'b0,4'd14,3'd1,32'h0,        1'b1,32'h0,       4'd4},  // R4
      '{1'b1,1'b0,4'd14,3'd2,32'h80000000, 1'b1,32'h0,       4'd4},  // R4
      '{1'b1,1'b1,4'd14,3'd0,32'hFFFFFFFF, 1'b0,32'h0,       4'd7},  // R7
      '{1'b0,1'b0,4'd14,3'd0,32'h0,        1'b0,32'h1,       4'd7},  // R7
      '{1'b0,1'b0,4'd12,3'd0,32'h0,        1'b0,32'h41000000,4'd8},  // R8
      '{1'b1,1'b0,4'd13,3'd1,32'hAB,       1'b0,32'h0,       4'd8},  // R8
      '{1'b0,1'b0,4'd13,3'd1,32'h0,        1'b0,32'hAB,      4'd8},  // R8
      '{1'b0,1'b0,4'd14,3'd1,32'h0,        1'b1,32'h0,       4'd4},  // R4
      '{1'b0,1'b1,4'd14,3'd1,32'h0,        1'b0,32'h80000000,4'd10}, // R10
      '{1'b0,1'b0,4'd13,3'd0,32'h0,        1'b0,32'h0,       4'd8},  // R8
      '{1'b0,1'b1,4'd12,3'd6,32'h0,        1'b1,32'h0,       4'd10}, // R10
      '{1'b1,1'b1,4'd12,3'd7,32'hFFFFFFFF, 1'b1,32'h0,       4'd10}, // R10
      '{1'b0,1'b1,4'd13,3'd3,32'h0,        1'b1,32'h0,       4'd10}, // R10
      '{1'b1,1'b1,4'd14,3'd3,32'hFFFFFFFF, 1'b1,32'h0,       4'd10}, // R10
      '{1'b1,1'b1,4'd15,3'd0,32'hFFFFFFFF, 1'b1,32'h0,       4'd10}, // R10
      '{1'b1,1'b1,4'd11,3'd1,32'hFFFFFFFF, 1'b1,32'h0,       4'd10}, // R10
      '{1'b0,1'b1,4'd12,3'd1,32'h0,        1'b0,32'h0,       4'd10}, // R10
      '{1'b0,1'b1,4'd12,3'd0,32'h0,        1'b0,32'h41000000,4'd10}, // R10
      '{1'b1,1'b1,4'd14,3'd0,32'h0,        1'b0,32'h0,       4'd7},  // R7
      '{1'b0,1'b0,4'd13,3'd1,32'h0,        1'b1,32'h0,       4'd8}   // R8
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] id_value = 32'h41C0FFEE;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [3:0]  acc_crm = '0;
   logic [2:0]  acc_op2 = '0;
   logic [31:0] acc_wdata = '0;
   logic        acc_priv = 1'b0;
   logic [31:0] rd_data;
   logic        acc_undef;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   perfmon_bank u_perfmon_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .id_value  (id_value),
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_crm   (acc_crm),
      .acc_op2   (acc_op2),
      .acc_wdata (acc_wdata),
      .acc_priv  (acc_priv),
      .rd_data   (rd_data),
      .acc_undef (acc_undef)
   );

   task automatic check(input string tag, input logic gu, input logic [31:0] gd,
                        input logic xu, input logic [31:0] xd);
      checks++;
      if (gu !== xu || gd !== xd) begin
         failures++;
         $display("FAIL %s: got undef=%0b data=%h, expected undef=%0b data=%h",
                  tag, gu, gd, xu, xd);
      end
   endtask

   task automatic access(input logic wr, input logic pv, input logic [3:0] crm,
                         input logic [2:0] op2, input logic [31:0] wd,
                         output logic und, output logic [31:0] rd);
      @(negedge clk);
      acc_valid = 1'b1;
      acc_write = wr;
      acc_priv  = pv;
      acc_crm   = crm;
      acc_op2   = op2;
      acc_wdata = wd;
      @(posedge clk);
      #1;
      und = acc_undef;
      rd  = rd_data;
      acc_valid = 1'b0;
   endtask

   task automatic idle_check(input string tag);
      @(negedge clk);
      acc_valid = 1'b0;
      @(posedge clk);
      #1;
      check(tag, acc_undef, rd_data, 1'b0, 32'h0);
   endtask

   task automatic do_reset(input logic [31:0] id);
      @(negedge clk);
      id_value = id;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      failures++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      logic        u;
      logic [31:0] d;
      do_reset(32'h41C0FFEE);
      // R1 / R11: outputs quiet straight after reset
      idle_check("R1 reset outputs");

      for (int i = 0; i < NV; i++) begin
         access(VECS[i].wr, VECS[i].pv, VECS[i].crm, VECS[i].op2, VECS[i].wd, u, d);
         check($sformatf("R%0d vector %0d", VECS[i].req, i), u, d, VECS[i].xu, VECS[i].xd);
      end

      // R11: an idle cycle after a read yields zero data and no trap
      access(1'b0, 1'b1, 4'd12, 3'd0, 32'h0, u, d);
      idle_check("R11 idle after read");
      // R11: a trapped access followed by idle clears the flag
      access(1'b0, 1'b1, 4'd15, 3'd7, 32'h0, u, d);
      check("R11 unmapped read", u, d, 1'b1, 32'h0);
      idle_check("R11 idle after trap");

      // R1: dirty state, then reset with another id value
      access(1'b1, 1'b1, 4'd14, 3'd0, 32'h1, u, d);
      access(1'b1, 1'b1, 4'd12, 3'd1, 32'h80000000, u, d);
      access(1'b1, 1'b1, 4'd12, 3'd0, 32'h39, u, d);
      do_reset(32'h5A0000FF);
      access(1'b0, 1'b1, 4'd12, 3'd0, 32'h0, u, d);
      check("R1 control after second reset", u, d, 1'b0, 32'h5A000000);
      access(1'b0, 1'b1, 4'd12, 3'd2, 32'h0, u, d);
      check("R1 count-enable after reset", u, d, 1'b0, 32'h0);
      access(1'b0, 1'b1, 4'd14, 3'd2, 32'h0, u, d);
      check("R1 interrupt-enable after reset", u, d, 1'b0, 32'h0);
      access(1'b0, 1'b1, 4'd13, 3'd1, 32'h0, u, d);
      check("R1 event type after reset", u, d, 1'b0, 32'h0);
      access(1'b0, 1'b0, 4'd12, 3'd3, 32'h0, u, d);
      check("R1 R8 user enable cleared by reset", u, d, 1'b1, 32'h0);

      // R2: a write of ones into the implementor byte is ignored
      access(1'b1, 1'b1, 4'd12, 3'd0, 32'hA5000008, u, d);
      access(1'b0, 1'b1, 4'd12, 3'd0, 32'h0, u, d);
      check("R2 implementor byte held", u, d, 1'b0, 32'h5A000008);

      finish_run();
   end

endmodule